// File: doc/BRIEF.md
# Mixed-Sign Single-Cycle Multiplier

This block multiplies two 16-bit operands in one clock. Each operand has its own signedness select, so a single signed array covers four cases: signed by signed, unsigned by unsigned, and both mixed orders. Each operand is first widened to 17 bits. A signed operand is sign-extended and an unsigned operand is zero-extended. The two 17-bit values are then multiplied as signed numbers. The exact product is 34 bits wide.

A mode bit selects how the product is presented. In integer mode the block returns the low 32 bits of the product. In fractional mode it shifts the product left by one place, which gives a 1.31 value. The one product that cannot be shown in 1.31 is -1.0 times -1.0, where both operands are signed 0x8000. For that case the block returns the largest positive value instead of letting the result wrap to a negative number, and it raises a flag.

The inputs are captured on a valid strobe. The result, the valid flag and the corner-case flag are registered and appear one clock later.

Top module: `mxm_top`

## Requirements
- R1: While `rst` is high, `res`, `res_valid` and `res_clip` all read 0 after the next clock edge.
- R2: `res_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1, and is 0 otherwise.
- R3: `res` and `res_clip` load only on an edge where `in_valid` is 1. On every other edge they keep their previous values.
- R4: When `a_sgn` (or `b_sgn`) is 1, bit 15 of that operand carries weight -32768, which means the operand is sign-extended.
- R5: When `a_sgn` (or `b_sgn`) is 0, that operand is read as an unsigned value from 0 to 65535, which means it is zero-extended.
- R6: The two operands may use different signedness. The product is exact for every combination of the two select bits.
- R7: With `frac` = 0, `res` is the low 32 bits of the exact product, with no shift applied.
- R8: With `frac` = 1, `res` is the low 32 bits of twice the exact product, which is the 1.31 format.
- R9: With `frac` = 1, `a_sgn` = `b_sgn` = 1 and both operands equal to 0x8000, `res` is 0x7FFFFFFF and `res_clip` is 1. For any other loaded operation `res_clip` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and modes are valid this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_sgn | input | 1 | 1 = `op_a` is signed, 0 = unsigned |
| b_sgn | input | 1 | 1 = `op_b` is signed, 0 = unsigned |
| frac | input | 1 | 1 = fractional 1.31 output, 0 = integer output |
| res | output | 32 | Registered product |
| res_valid | output | 1 | `res` was loaded on the last edge |
| res_clip | output | 1 | The last loaded result was the clipped -1.0 x -1.0 case |

## Verification
The assertions check the following on every cycle:
- the one-cycle relation between `in_valid` and `res_valid`;
- that `res` and `res_clip` hold their values when nothing is loaded;
- that a raised `res_clip` always comes with 0x7FFFFFFF, with fractional mode, and with two signed 0x8000 operands.

Only the bench scenarios can show that the arithmetic is exact. They compare the product against a model for each pairing of signedness, and in both output modes. Those scenarios include the operand extremes 0x8000 and 0xFFFF, and the clipping corner next to its neighbours that must not clip.

// File: rtl/mxm_pkg.sv
package mxm_pkg;

    // Operand, extended and product widths
    localparam int unsigned OP_W   = 16;
    localparam int unsigned EXT_W  = OP_W + 1;
    localparam int unsigned PROD_W = 2 * EXT_W;
    localparam int unsigned RES_W  = 2 * OP_W;

    typedef enum logic {
        FMT_INT  = 1'b0,
        FMT_FRAC = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [OP_W-1:0] val;
        logic            sgn;
    } operand_t;

    typedef struct packed {
        logic [RES_W-1:0] value;
        logic             clip;
    } result_t;

    // Largest positive result in the output format
    function automatic logic [RES_W-1:0] pos_max();
        return {1'b0, {(RES_W-1){1'b1}}};
    endfunction

    // Extended form of the most negative signed operand (-1.0 in Q15)
    function automatic logic [EXT_W-1:0] ext_neg_one();
        return {2'b11, {(OP_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/mxm_extend.sv
module mxm_extend
    import mxm_pkg::*;
(
    input  operand_t         op,
    output logic [EXT_W-1:0] ext
);
    // Sign or zero fill of the extra top bit
    always_comb begin
        ext = {op.sgn & op.val[OP_W-1], op.val};
    end

    always_comb begin
        if (!op.sgn) begin
            assert (ext[EXT_W-1] == 1'b0) else $error("AST_ZERO_FILL"); // R5
        end
    end
endmodule

// File: rtl/mxm_array.sv
module mxm_array
    import mxm_pkg::*;
(
    input  logic [EXT_W-1:0]  x,
    input  logic [EXT_W-1:0]  y,
    output logic [PROD_W-1:0] p
);
    logic signed [EXT_W-1:0]  xs;
    logic signed [EXT_W-1:0]  ys;
    logic signed [PROD_W-1:0] ps;

    always_comb begin
        xs = $signed(x);
        ys = $signed(y);
        ps = PROD_W'(xs) * PROD_W'(ys);
        p  = ps;
    end
endmodule

// File: rtl/mxm_format.sv
module mxm_format
    import mxm_pkg::*;
(
    input  logic [PROD_W-1:0] p,
    input  logic [EXT_W-1:0]  xa,
    input  logic [EXT_W-1:0]  xb,
    input  fmt_e              fmt,
    output result_t           r
);
    logic corner;
    logic unused_hi;

    assign unused_hi = ^p[PROD_W-1:RES_W];

    always_comb begin
        corner = (fmt == FMT_FRAC) && (xa == ext_neg_one()) && (xb == ext_neg_one());
        r.clip = corner;
        if (corner)
            r.value = pos_max();
        else if (fmt == FMT_FRAC)
            r.value = {p[RES_W-2:0], 1'b0};
        else
            r.value = p[RES_W-1:0];
    end

    always_comb begin
        if (r.clip) begin
            assert (r.value == pos_max()) else $error("AST_CLIP_VALUE"); // R9
        end
    end
endmodule

// File: rtl/mxm_top.sv
module mxm_top
    import mxm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             a_sgn,
    input  logic             b_sgn,
    input  logic             frac,
    output logic [RES_W-1:0] res,
    output logic             res_valid,
    output logic             res_clip
);
    localparam int unsigned N_OPS = 2;

    operand_t         ops [N_OPS];
    logic [EXT_W-1:0] exts[N_OPS];
    logic [PROD_W-1:0] prod;
    result_t          nxt;
    fmt_e             fmt;

    assign ops[0] = '{val: op_a, sgn: a_sgn};
    assign ops[1] = '{val: op_b, sgn: b_sgn};
    assign fmt    = frac ? FMT_FRAC : FMT_INT;

    for (genvar i = 0; i < N_OPS; i++) begin : g_ext
        mxm_extend u_ext (.op(ops[i]), .ext(exts[i]));
    end

    mxm_array u_arr (.x(exts[0]), .y(exts[1]), .p(prod));

    mxm_format u_fmt (.p(prod), .xa(exts[0]), .xb(exts[1]), .fmt(fmt), .r(nxt));

    always_ff @(posedge clk) begin
        if (rst) begin
            res       <= '0;
            res_clip  <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res      <= nxt.value;
                res_clip <= nxt.clip;
            end
        end
    end

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
        res_valid == $past(in_valid && !rst)) else $error("AST_VALID_LAG"); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(res) && $stable(res_clip))) else $error("AST_HOLD"); // R3
    AST_CLIP_OUT: assert property (@(posedge clk) disable iff (rst)
        res_clip |-> (res == pos_max())) else $error("AST_CLIP_OUT"); // R9
    AST_CLIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(res_clip) && res_valid) |-> $past(frac && a_sgn && b_sgn &&
            op_a == 16'h8000 && op_b == 16'h8000)) else $error("AST_CLIP_CAUSE"); // R9
    AST_RESET: assert property (@(posedge clk)
        $past(rst) |-> (res == '0 && !res_valid && !res_clip)) else $error("AST_RESET"); // R1
endmodule

// File: tb/sim_mxm_top.sv
module sim_mxm_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        a_sgn = 1'b0;
    logic        b_sgn = 1'b0;
    logic        frac = 1'b0;
    logic [31:0] res;
    logic        res_valid;
    logic        res_clip;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mxm_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .a_sgn(a_sgn), .b_sgn(b_sgn), .frac(frac),
        .res(res), .res_valid(res_valid), .res_clip(res_clip)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint model_val(input logic [15:0] a, input logic [15:0] b,
                                         input logic sa, input logic sb, input logic f);
        longint ea = sa ? longint'($signed(a)) : longint'(a);
        longint eb = sb ? longint'($signed(b)) : longint'(b);
        longint p = ea * eb;
        logic [63:0] pv;
        if (f && sa && sb && a == 16'h8000 && b == 16'h8000) return 64'h7FFFFFFF;
        pv = f ? 64'(p * 2) : 64'(p);
        return longint'(pv[31:0]);
    endfunction

    // Drive at a falling edge, check at the following falling edge
    task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic sa, input logic sb, input logic f);
        op_a = a; op_b = b; a_sgn = sa; b_sgn = sb; frac = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "res", longint'(res), model_val(a, b, sa, sb, f));
        chk(req, "res_valid", longint'(res_valid), 1);
        chk(req, "res_clip", longint'(res_clip),
            (f && sa && sb && a == 16'h8000 && b == 16'h8000) ? 1 : 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1", "res after reset", longint'(res), 0);
        chk("R1", "valid after reset", longint'(res_valid), 0);
        chk("R1", "clip after reset", longint'(res_clip), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_signed();
        run_op("R4", 16'hFFFD, 16'h0007, 1, 1, 0);
        run_op("R4", 16'h8000, 16'h8000, 1, 1, 0);
        run_op("R4", 16'h8000, 16'h7FFF, 1, 1, 0);
    endtask

    task automatic t_unsigned();
        run_op("R5", 16'hFFFF, 16'hFFFF, 0, 0, 0);
        run_op("R5", 16'h8000, 16'h0002, 0, 0, 0);
    endtask

    task automatic t_mixed();
        run_op("R6", 16'hFFFF, 16'h8000, 0, 1, 0);
        run_op("R6", 16'h8000, 16'hFFFF, 1, 0, 0);
        run_op("R6", 16'h1234, 16'hABCD, 1, 0, 1);
    endtask

    task automatic t_integer();
        run_op("R7", 16'd300, 16'd250, 0, 0, 0);
        run_op("R7", 16'h0000, 16'hFFFF, 1, 1, 0);
    endtask

    task automatic t_frac();
        run_op("R8", 16'h4000, 16'h4000, 1, 1, 1);
        run_op("R8", 16'h8000, 16'h7FFF, 1, 1, 1);
        run_op("R8", 16'hFFFF, 16'hFFFF, 0, 0, 1);
    endtask

    task automatic t_clip();
        run_op("R9", 16'h8000, 16'h8000, 1, 1, 1);
        run_op("R9", 16'h8000, 16'h8000, 0, 1, 1);
        run_op("R9", 16'h8000, 16'h8001, 1, 1, 1);
        run_op("R9", 16'h8000, 16'h8000, 1, 0, 1);
    endtask

    task automatic t_hold();
        run_op("R3", 16'h0123, 16'h0045, 0, 0, 0);
        op_a = 16'h7777; op_b = 16'h3333; frac = 1'b1;
        @(negedge clk);
        chk("R3", "res held", longint'(res), model_val(16'h0123, 16'h0045, 0, 0, 0));
        chk("R2", "valid low when idle", longint'(res_valid), 0);
        run_op("R9", 16'h8000, 16'h8000, 1, 1, 1);
        op_a = 16'h0001; op_b = 16'h0001; frac = 1'b0;
        @(negedge clk);
        chk("R3", "clip held", longint'(res_clip), 1);
    endtask

    task automatic t_back_to_back();
        op_a = 16'd10; op_b = 16'd20; a_sgn = 0; b_sgn = 0; frac = 0; in_valid = 1'b1;
        @(negedge clk);
        chk("R2", "first of pair", longint'(res), 200);
        chk("R2", "valid first", longint'(res_valid), 1);
        op_a = 16'hFFFF; op_b = 16'd3; a_sgn = 1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "second of pair", longint'(res), model_val(16'hFFFF, 16'd3, 1, 0, 0));
        chk("R2", "valid second", longint'(res_valid), 1);
        @(negedge clk);
        chk("R2", "valid drops", longint'(res_valid), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_signed();
        t_unsigned();
        t_mixed();
        t_integer();
        t_frac();
        t_clip();
        t_hold();
        t_back_to_back();
        run_op("R1", 16'h5555, 16'h0003, 0, 0, 0);
        t_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule